// File: doc/BRIEF.md
# Logic Channel Activity Classifier

This block watches a group of digital lines that share one sample clock and, over a measurement window of programmable length, gathers edge statistics for each line. For each channel it keeps the number of transitions in both directions, the shortest gap between two consecutive transitions, and how many samples the line spent high. From these it derives four results: the resting level, the minimum pulse width, a bit-rate estimate, and a coarse class. The class tells a quiet line, a line that belongs to a clocked multi-wire bus, and a lone asynchronous serial line apart.

A window starts on a start pulse. It opens either on the very next sample or, in trigger mode, on the first detected transition of one chosen channel. When the programmed number of samples has been taken, `done` rises and the statistics freeze until the next start. The per-channel results then leave on a valid/ready stream, one beat per channel in ascending channel order. A beat is taken when `res_valid` and `res_ready` are both high on a clock edge. While `res_valid` is high and `res_ready` is low, every result output holds its value. The sink may stall for any number of cycles. A new start drops the stream at once and discards the results still waiting.

Every input passes through a two-flop synchronizer before transitions are detected. The divider and the classifier are shared by all channels and serve the channel that the stream is currently presenting.

Top module: `chan_activity_classifier`

## Requirements
- R1: With `trig_mode` low, the window takes its first sample on the clock edge after the one that sees `start`. `done` is visible after exactly `window_len` sampling edges. A `window_len` of 0 behaves as 1. `done` reads 0 after reset and after every start.
- R2: `res_idle` is 1 when the channel was high in at least half of the window's samples, and 0 otherwise.
- R3: `res_edges` counts rising and falling transitions within the window. The count saturates at all ones and is cleared by every start.
- R4: `res_minw` is the smallest number of samples between two consecutive transitions in the window. It is all ones when the channel had fewer than two transitions.
- R5: `res_rate` equals SAMPLE_HZ divided by `res_minw`, truncated to an integer. It is 0 when the channel had fewer than two transitions.
- R6: `res_class` is 0 (static) for a channel with no transitions.
- R7: `res_class` is 1 (clocked bus) for a channel that has transitions, whose minimum width is at most SHORT_MAX, and whose edge count differs by a factor of at least SKEW_RATIO from that of some other channel with transitions. This rule outranks R8.
- R8: `res_class` is 2 (serial candidate) when the channel is the only one with transitions, has at least two of them and has a minimum width of at least SERIAL_MIN. Any other channel with transitions gets class 3 (unclassified).
- R9: With `trig_mode` high, the window opens on the sample where the first transition of channel `trig_sel` is detected. That transition is counted, and transitions seen on any channel before it are ignored.
- R10: After `done` rises it stays high, and the results stay unchanged whatever the inputs do, until the next start.
- R11: At the `done` cycle the stream presents channel 0 and then advances one channel per accepted beat, up to channel NUM_CH-1, after which `res_valid` falls. While the sink stalls, the beat holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_in | input | NUM_CH | Observed lines, asynchronous to clk |
| start | input | 1 | One-cycle pulse that clears the statistics and begins a window |
| trig_mode | input | 1 | When high, the window waits for an edge on trig_sel |
| trig_sel | input | $clog2(NUM_CH) | Channel whose first edge opens the window in trigger mode |
| window_len | input | 32 | Number of samples in the window |
| done | output | 1 | Window complete, results frozen |
| res_valid | output | 1 | Result beat available |
| res_ready | input | 1 | Sink accepts the beat |
| res_chan | output | $clog2(NUM_CH) | Channel index of the beat |
| res_idle | output | 1 | Resting level |
| res_edges | output | CNT_W | Transition count |
| res_minw | output | WID_W | Minimum pulse width in samples |
| res_rate | output | 32 | Bit-rate estimate in transitions per second |
| res_class | output | 2 | Class code: 0 static, 1 clocked bus, 2 serial, 3 unclassified |

## Verification
The hardest case to reach is trigger mode in which other channels toggle while the block is armed. Only the later transitions of the chosen channel may count, and the chosen channel's opening transition must itself be included. The stimulus toggles one channel several times right after start. It then waits longer than the synchronizer delay before the first edge on the trigger channel, and it expects that channel to be static and the trigger channel to be a lone serial line. The same run holds the sink back while the inputs churn after `done`, so the frozen results and the held beat are checked in one pass.

// File: rtl/lca_pkg.sv
package lca_pkg;

  typedef enum logic [1:0] {
    CLS_STATIC = 2'd0,
    CLS_SYNC   = 2'd1,
    CLS_SERIAL = 2'd2,
    CLS_OTHER  = 2'd3
  } chan_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } win_state_e;

endpackage

// File: rtl/lca_sync.sv
// Two-flop synchronizer plus one history flop for edge detection.
module lca_sync #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] smp,
  output logic [N-1:0] edg
);

  logic [N-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign smp = sync_q;
  assign edg = sync_q ^ hist_q;

endmodule

// File: rtl/lca_ctrl.sv
// Window sequencer: start, optional edge trigger, sample count, done.
module lca_ctrl
  import lca_pkg::*;
#(
  parameter int N     = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             trig_mode,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [31:0]      window_len,
  input  logic [N-1:0]     edg,
  output logic             clr,
  output logic             acc,
  output logic             load,
  output logic             done,
  output logic [31:0]      total
);

  win_state_e       st_q;
  logic [31:0]      cnt_q, wlen_q;
  logic [SEL_W-1:0] sel_q;
  logic             trig_hit, last;

  assign trig_hit = (st_q == ST_ARMED) && edg[sel_q];
  assign acc      = !start && ((st_q == ST_RUN) || trig_hit);
  assign last     = acc && ((cnt_q + 32'd1) >= wlen_q);
  assign load     = last;
  assign clr      = start;
  assign done     = (st_q == ST_DONE);
  assign total    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wlen_q <= '0;
      sel_q  <= '0;
    end else if (start) begin
      st_q   <= trig_mode ? ST_ARMED : ST_RUN;
      cnt_q  <= '0;
      wlen_q <= window_len;
      sel_q  <= trig_sel;
    end else if (acc) begin
      cnt_q <= cnt_q + 32'd1;
      st_q  <= last ? ST_DONE : ST_RUN;
    end
  end

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) done && !start |=> done); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> !done); // R1
  AST_NO_SAMPLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !acc); // R10

endmodule

// File: rtl/lca_chan_stats.sv
// Per-channel statistics: high-sample count, edge count, minimum width.
module lca_chan_stats #(
  parameter int CNT_W = 16,
  parameter int WID_W = 16,
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc,
  input  logic             smp,
  input  logic             edg,
  output logic [TOT_W-1:0] high_cnt,
  output logic [CNT_W-1:0] edges,
  output logic [WID_W-1:0] minw
);

  logic [WID_W-1:0] since_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt <= '0;
      edges    <= '0;
      minw     <= '1;
      since_q  <= '0;
      seen_q   <= 1'b0;
    end else if (clr) begin
      high_cnt <= '0;
      edges    <= '0;
      minw     <= '1;
      since_q  <= '0;
      seen_q   <= 1'b0;
    end else if (acc) begin
      if (smp) high_cnt <= high_cnt + TOT_W'(1);
      if (edg) begin
        if (edges != '1) edges <= edges + CNT_W'(1);
        if (seen_q && (since_q < minw)) minw <= since_q;
        since_q <= WID_W'(1);
        seen_q  <= 1'b1;
      end else if (since_q != '1) begin
        since_q <= since_q + WID_W'(1);
      end
    end
  end

  AST_MINW_NONINC: assert property (@(posedge clk) disable iff (!rst_n) !clr |=> minw <= $past(minw)); // R4
  AST_FROZEN_STATS: assert property (@(posedge clk) disable iff (!rst_n) !acc && !clr |=> $stable(edges) && $stable(high_cnt)); // R10
  AST_MINW_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n) edges < CNT_W'(2) |-> minw == '1); // R4

endmodule

// File: rtl/lca_report.sv
// Result stream with a shared divider and classifier for the presented channel.
module lca_report
  import lca_pkg::*;
#(
  parameter int N          = 16,
  parameter int SEL_W      = 4,
  parameter int CNT_W      = 16,
  parameter int WID_W      = 16,
  parameter int SAMPLE_HZ  = 50_000_000,
  parameter int SHORT_MAX  = 4,
  parameter int SERIAL_MIN = 8,
  parameter int SKEW_RATIO = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      load,
  input  logic [N-1:0][31:0]        high_cnt,
  input  logic [N-1:0][CNT_W-1:0]   edges,
  input  logic [N-1:0][WID_W-1:0]   minw,
  input  logic [31:0]               total,
  input  logic                      res_ready,
  output logic                      res_valid,
  output logic [SEL_W-1:0]          res_chan,
  output logic                      res_idle,
  output logic [CNT_W-1:0]          res_edges,
  output logic [WID_W-1:0]          res_minw,
  output logic [31:0]               res_rate,
  output logic [1:0]                res_class
);

  localparam int          PROD_W = CNT_W + 8;
  localparam logic [31:0] HZ     = 32'(SAMPLE_HZ);

  logic [SEL_W-1:0] ptr_q;
  logic             vld_q;
  logic [CNT_W-1:0] sel_e;
  logic [WID_W-1:0] sel_w;
  logic [SEL_W:0]   act_cnt;
  logic             skew;
  chan_class_e      cls;

  assign sel_e = edges[ptr_q];
  assign sel_w = minw[ptr_q];

  always_comb begin
    act_cnt = '0;
    for (int j = 0; j < N; j++) begin
      act_cnt = act_cnt + {{SEL_W{1'b0}}, (edges[j] != '0)};
    end
  end

  always_comb begin
    logic [PROD_W-1:0] a, b;
    skew = 1'b0;
    a    = PROD_W'(sel_e);
    for (int j = 0; j < N; j++) begin
      b = PROD_W'(edges[j]);
      if ((SEL_W'(j) != ptr_q) && (edges[j] != '0)) begin
        if ((a >= b * PROD_W'(SKEW_RATIO)) || (b >= a * PROD_W'(SKEW_RATIO))) skew = 1'b1;
      end
    end
  end

  always_comb begin
    if (sel_e == '0)
      cls = CLS_STATIC;
    else if ((sel_w <= WID_W'(SHORT_MAX)) && skew)
      cls = CLS_SYNC;
    else if ((act_cnt == (SEL_W+1)'(1)) && (sel_w != '1) && (sel_w >= WID_W'(SERIAL_MIN)))
      cls = CLS_SERIAL;
    else
      cls = CLS_OTHER;
  end

  always_comb begin
    if ((sel_w == '1) || (sel_w == '0))
      res_rate = '0;
    else
      res_rate = HZ / {{(32-WID_W){1'b0}}, sel_w};
  end

  assign res_idle  = ({high_cnt[ptr_q], 1'b0} >= {1'b0, total});
  assign res_valid = vld_q;
  assign res_chan  = ptr_q;
  assign res_edges = sel_e;
  assign res_minw  = sel_w;
  assign res_class = cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ptr_q <= '0;
    end else if (clr) begin
      vld_q <= 1'b0;
      ptr_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      ptr_q <= '0;
    end else if (vld_q && res_ready) begin
      if (ptr_q == SEL_W'(N-1)) vld_q <= 1'b0;
      else ptr_q <= ptr_q + SEL_W'(1);
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n) res_valid && !res_ready && !clr |=> res_valid && $stable(res_chan) && $stable(res_edges) && $stable(res_minw)); // R11
  AST_RATE_UNMEASURED: assert property (@(posedge clk) disable iff (!rst_n) res_valid && (res_edges < CNT_W'(2)) |-> res_rate == '0); // R5
  AST_STATIC_CLASS: assert property (@(posedge clk) disable iff (!rst_n) res_valid && (res_edges == '0) |-> res_class == 2'd0); // R6

endmodule

// File: rtl/chan_activity_classifier.sv
module chan_activity_classifier
  import lca_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CNT_W      = 16,
  parameter int WID_W      = 16,
  parameter int SAMPLE_HZ  = 50_000_000,
  parameter int SHORT_MAX  = 4,
  parameter int SERIAL_MIN = 8,
  parameter int SKEW_RATIO = 4,
  localparam int SEL_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_in,
  input  logic              start,
  input  logic              trig_mode,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [31:0]       window_len,
  output logic              done,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [SEL_W-1:0]  res_chan,
  output logic              res_idle,
  output logic [CNT_W-1:0]  res_edges,
  output logic [WID_W-1:0]  res_minw,
  output logic [31:0]       res_rate,
  output logic [1:0]        res_class
);

  logic [NUM_CH-1:0]             smp, edg;
  logic                          clr, acc, load;
  logic [31:0]                   total;
  logic [NUM_CH-1:0][31:0]       high_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0]  edges;
  logic [NUM_CH-1:0][WID_W-1:0]  minw;

  lca_sync #(.N(NUM_CH)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (ch_in), .smp (smp), .edg (edg)
  );

  lca_ctrl #(.N(NUM_CH), .SEL_W(SEL_W)) u_ctrl (
    .clk (clk), .rst_n (rst_n), .start (start), .trig_mode (trig_mode),
    .trig_sel (trig_sel), .window_len (window_len), .edg (edg),
    .clr (clr), .acc (acc), .load (load), .done (done), .total (total)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    lca_chan_stats #(.CNT_W(CNT_W), .WID_W(WID_W), .TOT_W(32)) u_stats (
      .clk (clk), .rst_n (rst_n), .clr (clr), .acc (acc),
      .smp (smp[c]), .edg (edg[c]),
      .high_cnt (high_cnt[c]), .edges (edges[c]), .minw (minw[c])
    );
  end

  lca_report #(
    .N(NUM_CH), .SEL_W(SEL_W), .CNT_W(CNT_W), .WID_W(WID_W), .SAMPLE_HZ(SAMPLE_HZ),
    .SHORT_MAX(SHORT_MAX), .SERIAL_MIN(SERIAL_MIN), .SKEW_RATIO(SKEW_RATIO)
  ) u_report (
    .clk (clk), .rst_n (rst_n), .clr (clr), .load (load),
    .high_cnt (high_cnt), .edges (edges), .minw (minw), .total (total),
    .res_ready (res_ready), .res_valid (res_valid), .res_chan (res_chan),
    .res_idle (res_idle), .res_edges (res_edges), .res_minw (res_minw),
    .res_rate (res_rate), .res_class (res_class)
  );

endmodule

// File: tb/chan_activity_classifier_tb.sv
module chan_activity_classifier_tb;

  localparam int N  = 16;
  localparam int HZ = 50_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] ch_in;
  logic        start, trig_mode, res_ready;
  logic [3:0]  trig_sel;
  logic [31:0] window_len;
  logic        done, res_valid, res_idle;
  logic [3:0]  res_chan;
  logic [15:0] res_edges, res_minw;
  logic [31:0] res_rate;
  logic [1:0]  res_class;

  always #10 clk = ~clk;

  chan_activity_classifier u_dut (
    .clk (clk), .rst_n (rst_n), .ch_in (ch_in), .start (start),
    .trig_mode (trig_mode), .trig_sel (trig_sel), .window_len (window_len),
    .done (done), .res_valid (res_valid), .res_ready (res_ready),
    .res_chan (res_chan), .res_idle (res_idle), .res_edges (res_edges),
    .res_minw (res_minw), .res_rate (res_rate), .res_class (res_class)
  );

  typedef struct {
    int     chan;
    int     idle;
    int     edges;
    int     minw;
    longint rate;
    int     cls;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;
  int   init_v[N], off_v[N], per_v[N], cnt_v[N];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ntog(input int c, input int s);
    int k;
    if (cnt_v[c] == 0 || s < off_v[c]) return 0;
    k = (s - off_v[c]) / per_v[c] + 1;
    return (k > cnt_v[c]) ? cnt_v[c] : k;
  endfunction

  function automatic bit is_tog(input int c, input int s);
    if (cnt_v[c] == 0 || s < off_v[c]) return 1'b0;
    return ((s - off_v[c]) % per_v[c] == 0) && ((s - off_v[c]) / per_v[c] < cnt_v[c]);
  endfunction

  function automatic logic vat(input int c, input int s);
    return logic'((init_v[c] ^ ntog(c, s)) & 1);
  endfunction

  task automatic clear_pat();
    for (int c = 0; c < N; c++) begin
      init_v[c] = 0; off_v[c] = 0; per_v[c] = 1; cnt_v[c] = 0;
    end
  endtask

  task automatic set_ch(input int c, input int o, input int p, input int n);
    off_v[c] = o; per_v[c] = p; cnt_v[c] = n;
  endtask

  // Monitor: pops expected results on each accepted beat.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (res_valid && res_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R11", "unexpected beat chan", res_chan, -1);
        end else begin
          exp_t e;
          string ctag;
          e = q.pop_front();
          ctag = (e.cls == 0) ? "R6" : (e.cls == 1) ? "R7" : "R8";
          check(res_chan == e.chan, "R11", "chan order", res_chan, e.chan);
          check(res_idle == e.idle[0], "R2", "idle level", res_idle, e.idle);
          check(res_edges == e.edges, "R3", "edge count", res_edges, e.edges);
          check(res_minw == e.minw, "R4", "min width", res_minw, e.minw);
          check(res_rate == e.rate, "R5", "bit rate", res_rate, e.rate);
          check(res_class == e.cls, ctag, "class", res_class, e.cls);
        end
      end
    end
  end

  // Driver: computes expectations from the requirements and drives the window.
  task automatic run_window(input int w, input bit tm, input int tsel, input bit stall);
    int b, weff, act, last, s_end;
    int e[N], mw[N], hi[N];
    bit got;
    b = -1;
    if (tm) begin
      for (int s = 0; s < 1000; s++) if (is_tog(tsel, s)) begin b = s; break; end
    end
    weff = (w < 1) ? 1 : w;
    act = 0;
    for (int c = 0; c < N; c++) begin
      last = -1; e[c] = 0; mw[c] = 65535; hi[c] = 0;
      for (int s = b; s < b + weff; s++) begin
        if (vat(c, s)) hi[c]++;
        if (is_tog(c, s)) begin
          if (last >= 0 && (s - last) < mw[c]) mw[c] = s - last;
          last = s;
          e[c]++;
        end
      end
      if (e[c] > 0) act++;
    end
    for (int c = 0; c < N; c++) begin
      exp_t x;
      bit sk;
      sk = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != c && e[j] > 0 && (e[c] >= 4 * e[j] || e[j] >= 4 * e[c])) sk = 1'b1;
      x.chan  = c;
      x.idle  = (2 * hi[c] >= weff) ? 1 : 0;
      x.edges = e[c];
      x.minw  = mw[c];
      x.rate  = (e[c] >= 2) ? (HZ / mw[c]) : 0;
      if (e[c] == 0) x.cls = 0;
      else if (mw[c] <= 4 && sk) x.cls = 1;
      else if (act == 1 && e[c] >= 2 && mw[c] >= 8) x.cls = 2;
      else x.cls = 3;
      q.push_back(x);
    end

    res_ready = !stall;
    repeat (5) begin
      @(negedge clk);
      for (int c = 0; c < N; c++) ch_in[c] = init_v[c][0];
    end
    got = 0;
    s_end = b + weff + 3;
    for (int s = 0; s <= s_end; s++) begin
      @(negedge clk);
      if (s == 1) check(done == 1'b0, "R1", "done after start", done, 0);
      if (s > 0 && !got && done) begin
        got = 1;
        check(s == b + weff + 2, "R1", "done step", s, b + weff + 2);
      end
      start      = (s == 0);
      trig_mode  = tm;
      trig_sel   = 4'(tsel);
      window_len = 32'(w);
      for (int c = 0; c < N; c++) ch_in[c] = vat(c, s);
    end
    if (!got) check(1'b0, "R1", "done never rose", 0, 1);

    if (stall) begin
      repeat (20) begin
        @(negedge clk);
        ch_in = ~ch_in;
      end
      check(res_valid == 1'b1, "R11", "valid held under stall", res_valid, 1);
      check(done == 1'b1, "R10", "done held while inputs churn", done, 1);
      for (int k = 0; k < 200 && q.size() > 0; k++) begin
        @(negedge clk);
        res_ready = (k % 3 != 0);
        ch_in = ch_in ^ 16'h00FF;
      end
    end else begin
      for (int k = 0; k < 200 && q.size() > 0; k++) @(negedge clk);
    end
    res_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R11", "all channels streamed", q.size(), 0);
    check(res_valid == 1'b0, "R11", "valid low after last channel", res_valid, 0);
    check(done == 1'b1, "R10", "done holds after stream", done, 1);
  endtask

  initial begin
    rst_n = 1'b0; ch_in = '0; start = 1'b0; trig_mode = 1'b0; trig_sel = '0;
    window_len = '0; res_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(res_valid == 1'b0, "R11", "valid after reset", res_valid, 0);

    // Lone serial-like line among static lines of mixed levels.
    clear_pat();
    for (int c = 0; c < N; c++) init_v[c] = (c % 3 == 0) ? 1 : 0;
    init_v[3] = 1;
    set_ch(3, 20, 25, 6);
    run_window(300, 1'b0, 0, 1'b0);

    // Clocked bus pair with a slow line and a medium line.
    clear_pat();
    init_v[1] = 1; init_v[9] = 1;
    set_ch(0, 10, 2, 60);
    set_ch(1, 30, 3, 6);
    set_ch(2, 40, 30, 10);
    set_ch(9, 50, 7, 2);
    run_window(400, 1'b0, 0, 1'b0);

    // R9: trigger on channel 5; ch7 toggles while armed and must be ignored.
    clear_pat();
    init_v[5] = 1;
    set_ch(7, 3, 2, 3);
    set_ch(5, 20, 12, 4);
    run_window(200, 1'b1, 5, 1'b1);

    // Single transition: width unmeasured, rate zero, unclassified.
    clear_pat();
    init_v[2] = 1;
    set_ch(2, 30, 1, 1);
    run_window(100, 1'b0, 0, 1'b0);

    // Zero-length window behaves as one sample.
    clear_pat();
    init_v[15] = 1;
    run_window(0, 1'b0, 0, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule